// File: doc/BRIEF.md
# Register Bank Select Control

This block holds a 32-bit select word that decides which copy of each duplicated register group is live, and which processor modes are active. An instruction decoder drives it with single-cycle command strobes: flip the bank of the accumulator and flags, of the general pairs, of the first index register, or of the second index register. One command flips all three address-register banks at once. Further commands set or clear mode bits, write the interrupt mode, and raise or drop the global interrupt enable. A whole-word load replaces the select word outright.

The stored word drives four bank-select lines into the register file and the mode outputs. It also supplies two small flag vectors, which the execution stage copies into its condition flags for the bank-test and mode-test operations. Every command takes effect on the clock edge that samples it. The select word, the bank lines and both flag vectors show the result one clock later.

Top module: `bsc_top`

## Requirements
- R1: After a synchronous active-low reset the select word is zero. All banks are primary, extended mode, long-word mode and lock are off, interrupts are disabled and the interrupt mode is 0.
- R2: The accumulator exchange strobe complements bit 0 of the select word and no other bit.
- R3: The general, first-index and second-index exchange strobes each complement only their own bit: bit 8, bit 16 and bit 24 respectively.
- R4: The exchange-all strobe complements bits 8, 16 and 24 together in one cycle and leaves bit 0 unchanged.
- R5: The set-mode strobe sets one bit chosen by the 2-bit selector: 0 picks lock (bit 1), 1 picks long-word (bit 6), 2 picks extended (bit 7). Code 3 changes nothing.
- R6: The clear-mode strobe clears lock (selector 0) or long-word (selector 1). Selector 2 or 3 leaves the word unchanged, so extended mode cannot be cleared.
- R7: The interrupt-mode strobe writes its 2-bit value into bits 4:3.
- R8: The enable strobe sets bit 5 and the disable strobe clears it. When both are asserted together, bit 5 ends up cleared.
- R9: Reserved bits always read zero. A load stores its data ANDed with 0x010101FB.
- R10: A load asserted in the same cycle as any other strobe sets the word to the load result, and the other strobes have no effect.
- R11: The bank-test vector, ordered {S, Z, V, C}, equals {bit 16, bit 24, bit 0, bit 8} of the select word.
- R12: The mode-test vector, ordered {S, Z, C}, equals {bit 7, bit 6, bit 1} of the select word.
- R13: The bank-select output, ordered {second index, first index, general, accumulator}, equals {bit 24, bit 16, bit 8, bit 0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xchg_acc | input | 1 | Flip accumulator/flag bank |
| xchg_gen | input | 1 | Flip general-pair bank |
| xchg_ix | input | 1 | Flip first index bank |
| xchg_iy | input | 1 | Flip second index bank |
| xchg_all | input | 1 | Flip general, first and second index banks together |
| mode_set | input | 1 | Set the mode bit chosen by mode_pick |
| mode_clr | input | 1 | Clear the mode bit chosen by mode_pick |
| mode_pick | input | 2 | 0 lock, 1 long-word, 2 extended |
| imode_wr | input | 1 | Write interrupt mode |
| imode_val | input | 2 | Interrupt mode value |
| ien_set | input | 1 | Enable interrupts |
| ien_clr | input | 1 | Disable interrupts |
| load_en | input | 1 | Whole-word load |
| load_data | input | 32 | Load value |
| sel_word | output | 32 | Current select word |
| bank_sel | output | 4 | {second index, first index, general, accumulator} bank selects |
| long_mode | output | 1 | Long-word mode active |
| ext_mode | output | 1 | Extended mode active |
| irq_en | output | 1 | Global interrupt enable |
| irq_mode | output | 2 | Interrupt mode |
| bank_flags | output | 4 | Bank-test flags {S,Z,V,C} |
| mode_flags | output | 3 | Mode-test flags {S,Z,C} |

## Verification
There is one register between a strobe and every output. A command sampled on a rising edge appears on sel_word, bank_sel, the mode outputs and both flag vectors after that same edge, so each result is due exactly one cycle after its strobe. The bench raises strobes just after a falling edge and lowers them at the next falling edge. It compares all outputs at that falling edge, half a period after the update, so every comparison reads the settled state one cycle after the stimulus. For commands that must have no effect, the bench reads the whole word at that point and checks that it still matches the previous value.

// File: rtl/bsc_pkg.sv
// Shared bit positions and masks for the bank select control word.
// Assumes a 32-bit word; positions are fixed because the register
// file and execution stage decode them.
package bsc_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned B_ACC   = 0;
    localparam int unsigned B_LOCK  = 1;
    localparam int unsigned B_IM_LO = 3;
    localparam int unsigned B_IEN   = 5;
    localparam int unsigned B_LONG  = 6;
    localparam int unsigned B_EXT   = 7;
    localparam int unsigned B_GEN   = 8;
    localparam int unsigned B_IX    = 16;
    localparam int unsigned B_IY    = 24;
    localparam logic [WORD_W-1:0] LIVE_MASK = 32'h0101_01FB;

    typedef enum logic [1:0] {
        PICK_LOCK = 2'd0,
        PICK_LONG = 2'd1,
        PICK_EXT  = 2'd2,
        PICK_NONE = 2'd3
    } mode_pick_e;
endpackage

// File: rtl/bsc_next.sv
// Next-state logic for the select word.
// Applies all bit commands in one pass, then lets a load override them,
// then masks reserved bits. Purely combinational.
module bsc_next
    import bsc_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic              xchg_acc,
    input  logic              xchg_gen,
    input  logic              xchg_ix,
    input  logic              xchg_iy,
    input  logic              xchg_all,
    input  logic              mode_set,
    input  logic              mode_clr,
    input  logic [1:0]        mode_pick,
    input  logic              imode_wr,
    input  logic [1:0]        imode_val,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_data,
    output logic [WORD_W-1:0] nxt
);
    localparam int unsigned NBANK = 4;
    localparam int unsigned BANK_POS [NBANK] = '{B_ACC, B_GEN, B_IX, B_IY};

    logic [NBANK-1:0] flip;
    logic [WORD_W-1:0] flip_vec;
    logic [WORD_W-1:0] cmd_val;

    // Per-bank flip requests; exchange-all covers the three address groups.
    assign flip = {xchg_iy | xchg_all, xchg_ix | xchg_all, xchg_gen | xchg_all, xchg_acc};

    // Spread the flip requests onto their word positions.
    generate
        for (genvar g = 0; g < WORD_W; g++) begin : g_flip
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int k = 0; k < NBANK; k++) begin
                    if (BANK_POS[k] == g) hit = flip[k];
                end
            end
            assign flip_vec[g] = hit;
        end
    endgenerate

    // Apply mode, interrupt and bank commands to the current word.
    always_comb begin
        cmd_val = cur ^ flip_vec;
        if (mode_set) begin
            case (mode_pick_e'(mode_pick))
                PICK_LOCK: cmd_val[B_LOCK] = 1'b1;
                PICK_LONG: cmd_val[B_LONG] = 1'b1;
                PICK_EXT:  cmd_val[B_EXT]  = 1'b1;
                default:   ;
            endcase
        end
        if (mode_clr) begin
            case (mode_pick_e'(mode_pick))
                PICK_LOCK: cmd_val[B_LOCK] = 1'b0;
                PICK_LONG: cmd_val[B_LONG] = 1'b0;
                default:   ;
            endcase
        end
        if (imode_wr) cmd_val[B_IM_LO +: 2] = imode_val;
        if (ien_set)  cmd_val[B_IEN] = 1'b1;
        if (ien_clr)  cmd_val[B_IEN] = 1'b0;
    end

    // Load wins over every bit command; reserved bits forced to zero.
    assign nxt = (load_en ? load_data : cmd_val) & LIVE_MASK;
endmodule

// File: rtl/bsc_flags.sv
// Output decode of the select word: bank selects, mode outputs and the
// flag vectors for the bank-test and mode-test operations.
// Assumes the word is already masked.
module bsc_flags
    import bsc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [3:0]        bank_sel,
    output logic [3:0]        bank_flags,
    output logic [2:0]        mode_flags,
    output logic              long_mode,
    output logic              ext_mode,
    output logic              irq_en,
    output logic [1:0]        irq_mode
);
    // Bank lines in {iy, ix, gen, acc} order.
    assign bank_sel   = {word[B_IY], word[B_IX], word[B_GEN], word[B_ACC]};
    // Bank test {S,Z,V,C}.
    assign bank_flags = {word[B_IX], word[B_IY], word[B_ACC], word[B_GEN]};
    // Mode test {S,Z,C}.
    assign mode_flags = {word[B_EXT], word[B_LONG], word[B_LOCK]};
    assign long_mode  = word[B_LONG];
    assign ext_mode   = word[B_EXT];
    assign irq_en     = word[B_IEN];
    assign irq_mode   = word[B_IM_LO +: 2];
endmodule

// File: rtl/bsc_top.sv
// Bank select control: holds the select word, updates it from decoder
// strobes and drives bank, mode and test-flag outputs.
// Assumes strobes are single-cycle pulses from the decoder.
module bsc_top
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xchg_acc,
    input  logic              xchg_gen,
    input  logic              xchg_ix,
    input  logic              xchg_iy,
    input  logic              xchg_all,
    input  logic              mode_set,
    input  logic              mode_clr,
    input  logic [1:0]        mode_pick,
    input  logic              imode_wr,
    input  logic [1:0]        imode_val,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              load_en,
    input  logic [31:0]       load_data,
    output logic [31:0]       sel_word,
    output logic [3:0]        bank_sel,
    output logic              long_mode,
    output logic              ext_mode,
    output logic              irq_en,
    output logic [1:0]        irq_mode,
    output logic [3:0]        bank_flags,
    output logic [2:0]        mode_flags
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;

    bsc_next u_next (
        .cur(word_q), .xchg_acc(xchg_acc), .xchg_gen(xchg_gen),
        .xchg_ix(xchg_ix), .xchg_iy(xchg_iy), .xchg_all(xchg_all),
        .mode_set(mode_set), .mode_clr(mode_clr), .mode_pick(mode_pick),
        .imode_wr(imode_wr), .imode_val(imode_val),
        .ien_set(ien_set), .ien_clr(ien_clr),
        .load_en(load_en), .load_data(load_data), .nxt(word_d)
    );

    // Select word register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    bsc_flags u_flags (
        .word(word_q), .bank_sel(bank_sel), .bank_flags(bank_flags),
        .mode_flags(mode_flags), .long_mode(long_mode), .ext_mode(ext_mode),
        .irq_en(irq_en), .irq_mode(irq_mode)
    );

    assign sel_word = word_q;

    // Accumulator exchange alone flips bit 0.
    assert_acc_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_acc && !load_en) |=> (sel_word[B_ACC] != $past(sel_word[B_ACC])));

    // Exchange-all alone flips the three address banks and keeps bit 0.
    assert_xall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_all && !load_en && !xchg_acc && !xchg_gen && !xchg_ix && !xchg_iy)
        |=> (bank_sel == ($past(bank_sel) ^ 4'b1110)));

    // Clear-mode never drops extended mode.
    assert_ext_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_clr && !load_en && $past(rst_n) && ext_mode) |=> ext_mode);

    // Load result takes priority.
    assert_load_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (sel_word == ($past(load_data) & LIVE_MASK)));

    // Reserved bits read zero.
    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sel_word & ~LIVE_MASK) == '0));
endmodule

// File: tb/sim_bsc_top.sv
module sim_bsc_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xchg_acc = 0, xchg_gen = 0, xchg_ix = 0, xchg_iy = 0, xchg_all = 0;
    logic mode_set = 0, mode_clr = 0, imode_wr = 0, ien_set = 0, ien_clr = 0, load_en = 0;
    logic [1:0] mode_pick = 0, imode_val = 0;
    logic [31:0] load_data = 0;
    logic [31:0] sel_word;
    logic [3:0] bank_sel, bank_flags;
    logic [2:0] mode_flags;
    logic [1:0] irq_mode;
    logic long_mode, ext_mode, irq_en;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bsc_top u0 (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic idle();
        {xchg_acc, xchg_gen, xchg_ix, xchg_iy, xchg_all} = '0;
        {mode_set, mode_clr, imode_wr, ien_set, ien_clr, load_en} = '0;
    endtask

    // Hold the strobes set by the caller for one cycle, then clear them.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        chk("R1 word", sel_word, 32'h0);
        chk("R1 banks", {28'h0, bank_sel}, 32'h0);
        chk("R1 modes", {28'h0, long_mode, ext_mode, irq_en, irq_mode == 2'b00}, 32'h1);
    endtask

    task automatic t_bank_flips();
        xchg_acc = 1; step();
        chk("R2 acc flip", sel_word, 32'h0000_0001);
        chk("R11 V flag", {28'h0, bank_flags}, 32'h2);
        xchg_gen = 1; step();
        chk("R3 gen flip", sel_word, 32'h0000_0101);
        xchg_ix = 1; step();
        chk("R3 ix flip", sel_word, 32'h0001_0101);
        xchg_iy = 1; step();
        chk("R3 iy flip", sel_word, 32'h0101_0101);
        chk("R13 bank_sel", {28'h0, bank_sel}, 32'hF);
        chk("R11 all flags", {28'h0, bank_flags}, 32'hF);
        xchg_all = 1; step();
        chk("R4 xall keeps bit0", sel_word, 32'h0000_0001);
        xchg_acc = 1; step();
        xchg_all = 1; step();
        chk("R4 xall sets three", sel_word, 32'h0101_0100);
        chk("R13 bank_sel xall", {28'h0, bank_sel}, 32'hE);
    endtask

    task automatic t_modes();
        load_en = 1; load_data = 0; step();
        mode_set = 1; mode_pick = 2'd0; step();
        mode_set = 1; mode_pick = 2'd1; step();
        mode_set = 1; mode_pick = 2'd2; step();
        chk("R5 set all", sel_word, 32'h0000_00C2);
        chk("R12 mode flags", {29'h0, mode_flags}, 32'h7);
        mode_set = 1; mode_pick = 2'd3; step();
        chk("R5 pick3 no effect", sel_word, 32'h0000_00C2);
        mode_clr = 1; mode_pick = 2'd2; step();
        chk("R6 ext not cleared", sel_word, 32'h0000_00C2);
        mode_clr = 1; mode_pick = 2'd3; step();
        chk("R6 pick3 no effect", sel_word, 32'h0000_00C2);
        mode_clr = 1; mode_pick = 2'd1; step();
        chk("R6 clr long", sel_word, 32'h0000_0082);
        mode_clr = 1; mode_pick = 2'd0; step();
        chk("R6 clr lock", sel_word, 32'h0000_0080);
        chk("R12 ext only", {29'h0, mode_flags}, 32'h4);
        chk("R5 ext output", {31'h0, ext_mode}, 32'h1);
    endtask

    task automatic t_irq();
        imode_wr = 1; imode_val = 2'b10; step();
        chk("R7 imode 2", sel_word, 32'h0000_0090);
        chk("R7 irq_mode", {30'h0, irq_mode}, 32'h2);
        ien_set = 1; step();
        chk("R8 enable", sel_word, 32'h0000_00B0);
        ien_set = 1; ien_clr = 1; step();
        chk("R8 both clears", {31'h0, irq_en}, 32'h0);
    endtask

    task automatic t_load();
        load_en = 1; load_data = 32'hFFFF_FFFF; step();
        chk("R9 load mask", sel_word, 32'h0101_01FB);
        load_en = 1; load_data = 32'h0; xchg_all = 1; xchg_acc = 1;
        mode_set = 1; mode_pick = 2'd0; ien_set = 1; imode_wr = 1; imode_val = 2'b11; step();
        chk("R10 load priority", sel_word, 32'h0);
        load_en = 1; load_data = 32'h0100_0042; step();
        chk("R11 bank flags", {28'h0, bank_flags}, 32'h4);
        chk("R12 mode flags", {29'h0, mode_flags}, 32'h3);
        chk("R13 bank_sel iy", {28'h0, bank_sel}, 32'h8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank_flips();
        t_modes();
        t_irq();
        t_load();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1 got=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule